// File: doc/BRIEF.md
# Recovered Clock Halver with Phase Alignment

This block sits on the one end of a serial link that turns its receiver's recovered strobe into its own transmit word clock. Both directions then run from a single system clock. The block is clocked directly by the recovered strobe. In single-frame operation the strobe already runs at the word rate and is used unchanged, so the block holds its divider idle. In double-frame operation the strobe runs at twice the word rate, and a toggle flop halves it.

Halving from an arbitrary starting edge can land the divided clock on the wrong one of the two possible phases. Once both ends report lock, the receiver's frame-phase flag shows which phase the divider is on. If the flag is high on an edge where the divided clock is about to rise, the block suppresses that single toggle. This moves the divided clock by one strobe period and makes the link drop lock and acquire it again, this time in phase. Only one slip is allowed per lock episode. The block also provides a lock indicator that is high only while both ends are locked.

Top module: `rch_clock_halver`

## Requirements
- R1: While `rst_n` is low, `half_clk`, `slip_pulse` and `lock_ind` are all 0.
- R2: In double-frame mode (`double_frame` = 1 at an edge), `half_clk` inverts at every strobe edge, except at an edge where a slip is taken.
- R3: In single-frame mode (`double_frame` = 0 at an edge), `half_clk` is 0 after that edge and no slip is ever taken.
- R4: `lock_ind` is high only while both `lock_near` and `lock_far` are high. Each passes through a two-flop synchronizer, so `lock_ind` after edge n equals `lock_near` AND `lock_far` as sampled at edge n-1.
- R5: A slip is taken at an edge where the block is in double-frame mode, `lock_ind` is 1, slipping is armed, `half_clk` is 0 and `phase_flag` is 1. At that edge `half_clk` stays 0 instead of rising, and `slip_pulse` is 1 for the following cycle.
- R6: `phase_flag` has no effect on an edge where `half_clk` is 1: the divided clock falls as usual and no slip occurs.
- R7: `phase_flag` has no effect while `lock_ind` is 0 (the acquisition phase): no slip occurs.
- R8: After a slip, no further slip is taken until `lock_ind` has been sampled low at some edge and then goes high again. Slipping is armed after reset.
- R9: `slip_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive strobe, used as the block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| double_frame | input | 1 | 1 = strobe is at twice the word rate (divide), 0 = strobe used directly |
| lock_near | input | 1 | Asynchronous lock status of this end |
| lock_far | input | 1 | Asynchronous lock status of the other end |
| phase_flag | input | 1 | Frame-phase flag from the receiver, high when the divided phase is wrong |
| half_clk | output | 1 | Divided transmit word clock (held 0 in single-frame mode) |
| slip_pulse | output | 1 | One-cycle pulse marking a suppressed toggle |
| lock_ind | output | 1 | Both ends locked, for an indicator |

## Verification
On every cycle, the bound checker confirms four things: the divider toggles or holds according to the mode, a slip only ever replaces a rising edge after a flagged and locked edge, the indicator follows the synchronized pair of lock inputs, and at most one slip pulse occurs per lock episode. Some behaviour is visible only through the bench's stimulus. This covers whether a flag on a falling edge or during acquisition is truly ignored, whether re-arming actually happens after lock is lost and regained, and whether the mode switch stops the divider. To show these, the bench runs a model-compared sweep over pseudo-random flag, lock and mode patterns and a set of directed sequences.

// File: rtl/rch_pkg.sv
package rch_pkg;
   // Frame mode as seen by the divider
   typedef enum logic {
      FRAME_SINGLE = 1'b0,
      FRAME_DOUBLE = 1'b1
   } frame_mode_e;

   // Outcome of a phase check at one strobe edge
   typedef struct packed {
      logic take_slip;   // suppress the toggle at this edge
      logic armed;       // slipping currently allowed
   } phase_verdict_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/rch_lock_sync.sv
module rch_lock_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < rch_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("rch_lock_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rch_lock_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain <= {chain[STAGES-2:0], async_in[b]};
         end
      end
      assign sync_out[b] = chain[LAST];
   end
endmodule

// File: rtl/rch_phase_check.sv
module rch_phase_check #(
   parameter bit ONE_SLIP_PER_LOCK = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  rch_pkg::frame_mode_e    mode,
   input  logic                    link_up,
   input  logic                    half_q,
   input  logic                    flag,
   output rch_pkg::phase_verdict_t verdict,
   output logic                    slip_pulse
);
   logic armed_q;
   logic rising_edge_next;
   logic allowed;

   // The divider rises at this edge when it is low and dividing
   assign rising_edge_next = (mode == rch_pkg::FRAME_DOUBLE) && !half_q;

   if (ONE_SLIP_PER_LOCK) begin : g_once
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b1;
         end else if (!link_up) begin
            armed_q <= 1'b1;
         end else if (verdict.take_slip) begin
            armed_q <= 1'b0;
         end
      end
      assign allowed = armed_q;
   end else begin : g_every
      assign armed_q = 1'b1;
      assign allowed = 1'b1;
   end

   assign verdict.take_slip = rising_edge_next && link_up && allowed && flag;
   assign verdict.armed     = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slip_pulse <= 1'b0;
      end else begin
         slip_pulse <= verdict.take_slip;
      end
   end
endmodule

// File: rtl/rch_halver.sv
module rch_halver #(
   parameter bit SUPPORT_DOUBLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  rch_pkg::frame_mode_e mode,
   input  logic                 suppress,
   output logic                 half_q
);
   if (SUPPORT_DOUBLE) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= 1'b0;
         end else if (mode == rch_pkg::FRAME_SINGLE) begin
            half_q <= 1'b0;
         end else if (!suppress) begin
            half_q <= ~half_q;
         end
      end
   end else begin : g_nodiv
      assign half_q = 1'b0;
   end
endmodule

// File: rtl/rch_clock_halver.sv
module rch_clock_halver #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter bit          SUPPORT_DOUBLE    = 1'b1,
   parameter bit          ONE_SLIP_PER_LOCK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic double_frame,
   input  logic lock_near,
   input  logic lock_far,
   input  logic phase_flag,
   output logic half_clk,
   output logic slip_pulse,
   output logic lock_ind
);
   import rch_pkg::*;

   localparam int unsigned LOCK_SOURCES = 2;

   logic [LOCK_SOURCES-1:0] lock_sync;
   logic                    link_up;
   frame_mode_e             mode;
   phase_verdict_t          verdict;
   logic                    half_q;

   assign mode = (double_frame && SUPPORT_DOUBLE) ? FRAME_DOUBLE : FRAME_SINGLE;

   rch_lock_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LOCK_SOURCES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({lock_far, lock_near}),
      .sync_out (lock_sync)
   );

   assign link_up = &lock_sync;

   rch_phase_check #(
      .ONE_SLIP_PER_LOCK (ONE_SLIP_PER_LOCK)
   ) u_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .link_up    (link_up),
      .half_q     (half_q),
      .flag       (phase_flag),
      .verdict    (verdict),
      .slip_pulse (slip_pulse)
   );

   rch_halver #(
      .SUPPORT_DOUBLE (SUPPORT_DOUBLE)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .suppress (verdict.take_slip),
      .half_q   (half_q)
   );

   assign half_clk = half_q;
   assign lock_ind = link_up;
endmodule

// File: rtl/rch_clock_halver_chk.sv
module rch_clock_halver_chk #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter bit          ONE_SLIP_PER_LOCK = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic double_frame,
   input logic lock_near,
   input logic lock_far,
   input logic phase_flag,
   input logic half_clk,
   input logic slip_pulse,
   input logic lock_ind
);
   logic episode_used;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         episode_used <= 1'b0;
      end else if (!lock_ind) begin
         episode_used <= 1'b0;
      end else if (slip_pulse) begin
         episode_used <= 1'b1;
      end
   end

   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(double_frame) && !slip_pulse) |-> (half_clk != $past(half_clk)));

   assert_single_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(double_frame)) |-> (!half_clk && !slip_pulse));

   if (SYNC_STAGES == 2) begin : g_lat
      assert_lock_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lock_ind |-> ($past(lock_near, 2) && $past(lock_far, 2)));
   end

   assert_slip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pulse |-> (!half_clk && !$past(half_clk) && $past(double_frame)));

   assert_slip_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pulse |-> ($past(lock_ind) && $past(phase_flag)));

   if (ONE_SLIP_PER_LOCK) begin : g_once
      assert_one_per_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
         slip_pulse |-> !episode_used);
   end

   assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pulse |=> !slip_pulse);
endmodule

bind rch_clock_halver rch_clock_halver_chk #(
   .SYNC_STAGES       (SYNC_STAGES),
   .ONE_SLIP_PER_LOCK (ONE_SLIP_PER_LOCK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .double_frame (double_frame),
   .lock_near    (lock_near),
   .lock_far     (lock_far),
   .phase_flag   (phase_flag),
   .half_clk     (half_clk),
   .slip_pulse   (slip_pulse),
   .lock_ind     (lock_ind)
);

// File: tb/rch_clock_halver_test.sv
`timescale 1ns/1ps
module rch_clock_halver_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic double_frame = 1'b0;
   logic lock_near = 1'b0;
   logic lock_far = 1'b0;
   logic phase_flag = 1'b0;
   logic half_clk, slip_pulse, lock_ind;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   rch_clock_halver uut (
      .clk(clk), .rst_n(rst_n), .double_frame(double_frame),
      .lock_near(lock_near), .lock_far(lock_far), .phase_flag(phase_flag),
      .half_clk(half_clk), .slip_pulse(slip_pulse), .lock_ind(lock_ind)
   );

   // Reference model built from the requirements
   logic [1:0] m_s1, m_s2;
   logic m_div, m_arm, m_slip, m_up, m_det;
   assign m_up  = &m_s2;
   assign m_det = double_frame && m_up && m_arm && !m_div && phase_flag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 2'b00; m_s2 <= 2'b00; m_div <= 1'b0; m_arm <= 1'b1; m_slip <= 1'b0;
      end else begin
         m_s1   <= {lock_far, lock_near};
         m_s2   <= m_s1;
         m_div  <= double_frame ? (m_det ? m_div : ~m_div) : 1'b0;
         m_arm  <= !m_up ? 1'b1 : (m_det ? 1'b0 : m_arm);
         m_slip <= m_det;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic compare_model();
      check(double_frame ? "R2 half_clk vs model" : "R3 half_clk vs model", half_clk, m_div);
      check("R5 slip_pulse vs model", slip_pulse, m_slip);
      check("R4 lock_ind vs model", lock_ind, m_up);
   endtask

   // Drive inputs after a falling edge, pass one rising edge, sample at the next falling edge
   task automatic step(input logic dbl, input logic ln, input logic lf, input logic fl);
      double_frame = dbl; lock_near = ln; lock_far = lf; phase_flag = fl;
      @(posedge clk);
      @(negedge clk);
      cyc++;
      compare_model();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic prev;
      logic [15:0] lfsr;
      logic dbl_r;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 half_clk in reset", half_clk, 1'b0);
      check("R1 slip_pulse in reset", slip_pulse, 1'b0);
      check("R1 lock_ind in reset", lock_ind, 1'b0);
      rst_n = 1'b1;

      // R2 and R7: dividing during acquisition, flag high all the time, no slip
      prev = half_clk;
      for (int i = 0; i < 12; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b1);
         check("R2 toggle each edge", half_clk, ~prev);
         check("R7 no slip while unlocked", slip_pulse, 1'b0);
         prev = half_clk;
      end

      // R4: one side only never lights the indicator
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1'b1, 1'b0, 1'b0);
         check("R4 near only", lock_ind, 1'b0);
      end
      step(1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      check("R4 far only", lock_ind, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R4 one edge after both", lock_ind, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R4 two edges after both", lock_ind, 1'b1);

      // R6: flag only on edges where half_clk is high
      for (int i = 0; i < 8; i++) begin
         prev = half_clk;
         step(1'b1, 1'b1, 1'b1, half_clk);
         check("R6 falling edge ignores flag", half_clk, ~prev);
         check("R6 no slip on falling edge", slip_pulse, 1'b0);
      end

      // R5: flag on a rising edge suppresses the toggle
      if (half_clk) step(1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b1);
      check("R5 toggle suppressed", half_clk, 1'b0);
      check("R5 slip pulse", slip_pulse, 1'b1);
      step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R9 pulse one cycle", slip_pulse, 1'b0);
      check("R5 resumes rising", half_clk, 1'b1);

      // R8: no second slip in the same lock episode
      for (int i = 0; i < 10; i++) begin
         prev = half_clk;
         step(1'b1, 1'b1, 1'b1, 1'b1);
         check("R8 no repeat slip", slip_pulse, 1'b0);
         check("R8 toggling continues", half_clk, ~prev);
      end
      // lose lock, regain, then a slip is allowed again
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R8 relocked", lock_ind, 1'b1);
      if (half_clk) step(1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b1);
      check("R8 rearmed slip", slip_pulse, 1'b1);

      // R3: single-frame mode, flag high, locked
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         step(1'b0, 1'b1, 1'b1, 1'b1);
         check("R3 no division", half_clk, 1'b0);
         check("R3 no slip", slip_pulse, 1'b0);
      end

      // Sweep: pseudo-random flag, lock and mode patterns against the model
      lfsr = 16'hACE1;
      dbl_r = 1'b1;
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (i % 700 == 699) dbl_r = ~dbl_r;
         step(dbl_r, lfsr[7:4] != 4'h0, lfsr[11:8] != 4'h0, lfsr[1:0] == 2'b11);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule